// File: doc/BRIEF.md
# Camera Sensor Pixel Capture Front-End

This block takes pixel samples from an image sensor on a parallel bus. Everything runs in the sensor's pixel clock domain. A frame strobe and a line strobe mark which cycles carry active pixels. The selected sample width is 8, 9 or 10 bits. The block counts pixels within a line and lines within a frame against programmed limits. It packs the accepted samples into 64-bit words and stores them in a 16-entry FIFO. A DMA engine drains the FIFO through a valid/ready handshake.

Three sticky flags record events: end of line, end of frame and a word lost to a full FIFO. Software clears a flag by writing 1 to it. A mask selects which flags drive the single interrupt line.

A frame-tracking state machine runs the control. Its states are:

- `ST_IDLE`: waits for the frame strobe to rise.
- `ST_SKIP`: a frame seen while capture is disabled.
- `ST_WAIT_LINE`: inside a frame, between lines.
- `ST_ACTIVE`: taking samples of a line.
- `ST_DISCARD`: the rest of a line that has already reached its width.
- `ST_FRAME_DONE`: the rest of a frame that has already reached its height.

Its transitions are:

- IDLE to WAIT_LINE: frame rise with capture enabled.
- IDLE to SKIP: frame rise with capture disabled.
- WAIT_LINE to ACTIVE: first sample of a line.
- WAIT_LINE or ACTIVE to DISCARD: width reached.
- ACTIVE to WAIT_LINE: line strobe fell.
- ACTIVE or WAIT_LINE to FRAME_DONE: height reached on a line end.
- Any frame state to IDLE: frame strobe fell.

Top module: `cam_capture_front`

## Requirements
- R1: `cfg_width` selects the sample format, and it is latched only at a frame-strobe rise. Code 0 selects 8 bits, taken from `pix_data[7:0]`. Code 1 selects 9 bits, taken from `pix_data[8:0]`. Codes 2 and 3 select 10 bits, taken from `pix_data[9:0]`.
- R2: In 8-bit format, eight samples fill a word, and sample k of a word sits at bits [8k+7:8k]. In 9- and 10-bit formats, each sample is zero-extended to 16 bits, four samples fill a word, and sample k sits at bits [16k+15:16k].
- R3: A sample is accepted only in a cycle where both strobes are high, inside a frame whose capture was enabled. Each such cycle yields exactly one sample.
- R4: A line ends at one of two points, whichever comes first:
  - the cycle its accepted-sample count reaches `cfg_hsize`, with that sample included;
  - the cycle the line strobe falls.
  
  Samples after the end of a line are discarded. A partly filled word is pushed, zero-padded, at the line end. A line end never pushes an empty word, and it pushes only one word when the last sample also fills the word.
- R5: A frame ends at one of two points, whichever comes first:
  - the line end that makes the line count reach `cfg_vsize`;
  - the fall of the frame strobe.
  
  Lines after the end of a frame are ignored. The pixel and line counts restart at each frame-strobe rise, which also latches `cfg_hsize` and `cfg_vsize`.
- R6: `cfg_capture_en` is sampled only at a frame-strobe rise. A frame that starts with capture disabled produces no words and sets no flag. Changing the enable in the middle of a frame has no effect on that frame.
- R7: The FIFO holds 16 words. `rd_valid` is high while it is non-empty, and `rd_data` shows the oldest word. A word leaves the FIFO in a cycle with both `rd_valid` and `rd_ready` high. While it is not taken, the head word stays stable. Words come out in the order they were pushed.
- R8: The flags are positioned as follows:

  | Bit | Flag |
  |---|---|
  | `flags[0]` | end of line |
  | `flags[1]` | end of frame |
  | `flags[2]` | overflow |

  Each flag is set at the clock edge that ends the cycle of its event, and it stays set until a 1 is written to the same bit of `flag_clear`. If an event and a clear fall in the same cycle, the flag stays set.
- R9: A word pushed while the FIFO is full, in a cycle where no word is read, is dropped and sets the overflow flag. The stored words are unchanged.
- R10: `irq` is high exactly when some flag is set and its bit in `irq_mask` is 1.
- R11: After reset, all flags are 0, `irq` is 0, `rd_valid` is 0 and the machine waits for a frame rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sensor pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_data | input | 10 | Sample bus from the sensor |
| line_valid | input | 1 | High during the active part of a line |
| frame_valid | input | 1 | High during the active part of a frame |
| cfg_width | input | 2 | Sample format code (0: 8-bit, 1: 9-bit, 2/3: 10-bit) |
| cfg_hsize | input | 12 | Samples per line, 1 to 2048 |
| cfg_vsize | input | 12 | Lines per frame, 1 to 2048 |
| cfg_capture_en | input | 1 | Capture enable, sampled at frame rise |
| rd_data | output | 64 | Oldest packed word in the FIFO |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_ready | input | 1 | Reader takes the head word |
| flag_clear | input | 3 | Write-1-to-clear strobes for the flags |
| irq_mask | input | 3 | Per-flag interrupt enable |
| flags | output | 3 | Sticky flags: end of line, end of frame, overflow |
| irq | output | 1 | Masked OR of the flags |

## Verification
Two kinds of event can fall in the same cycle:

- **Word full and line end.** The sample that fills the last lane of a word can also be the sample that reaches the programmed width. The bench provokes this with an 8-bit, width-8 frame. It judges the result by counting the words drained: there must be exactly one per line, with no empty trailing word.
- **Flag set and flag clear.** A write-1 clear of the end-of-line flag can land in the very cycle that line ends. The bench drives the clear alongside that last sample. It expects the flag to stay set, and a later isolated clear to remove it.

Both cases sit alongside a sweep over the three formats, several widths around each line length, and two heights. For that sweep, the expected words are computed arithmetically from the sample pattern.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int WORD_W    = 64;
    localparam int NUM_FLAGS = 3;
    localparam int FLAG_EOL  = 0;
    localparam int FLAG_EOF  = 1;
    localparam int FLAG_OVF  = 2;

    typedef enum logic [1:0] {
        WM_8   = 2'd0,
        WM_9   = 2'd1,
        WM_10  = 2'd2,
        WM_10B = 2'd3
    } wmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_WAIT_LINE,
        ST_ACTIVE,
        ST_DISCARD,
        ST_FRAME_DONE
    } cap_state_e;

endpackage

// File: rtl/cap_frame_fsm.sv
module cap_frame_fsm
    import cap_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_valid,
    input  logic             line_valid,
    input  logic             cfg_capture_en,
    input  logic [1:0]       cfg_width,
    input  logic [DIM_W-1:0] cfg_hsize,
    input  logic [DIM_W-1:0] cfg_vsize,
    output logic             accept,
    output logic             line_end,
    output logic             frame_end,
    output wmode_e           width_q
);

    cap_state_e       state, nxt;
    logic             frame_q;
    logic             start;
    logic [DIM_W-1:0] pix_cnt, line_cnt;
    logic [DIM_W-1:0] hsize_q, vsize_q;
    logic [DIM_W-1:0] pix_inc, line_inc;
    logic             hit_w, hit_h, frame_rise;

    assign frame_rise = frame_valid && !frame_q;
    assign pix_inc    = pix_cnt + DIM_W'(1);
    assign line_inc   = line_cnt + DIM_W'(1);
    assign hit_w      = (pix_inc == hsize_q);
    assign hit_h      = (line_inc == vsize_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            frame_q <= 1'b0;
        end else begin
            state   <= nxt;
            frame_q <= frame_valid;
        end
    end

    // next state and event outputs
    always_comb begin
        nxt       = state;
        accept    = 1'b0;
        line_end  = 1'b0;
        frame_end = 1'b0;
        start     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (frame_rise) begin
                    start = 1'b1;
                    nxt   = cfg_capture_en ? ST_WAIT_LINE : ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (!frame_valid) nxt = ST_IDLE;
            end
            ST_WAIT_LINE: begin
                if (!frame_valid) begin
                    frame_end = 1'b1;
                    nxt       = ST_IDLE;
                end else if (line_valid) begin
                    accept = 1'b1;
                    if (hit_w) begin
                        line_end = 1'b1;
                        if (hit_h) begin
                            frame_end = 1'b1;
                            nxt       = ST_FRAME_DONE;
                        end else begin
                            nxt = ST_DISCARD;
                        end
                    end else begin
                        nxt = ST_ACTIVE;
                    end
                end
            end
            ST_ACTIVE: begin
                if (!frame_valid) begin
                    line_end  = 1'b1;
                    frame_end = 1'b1;
                    nxt       = ST_IDLE;
                end else if (!line_valid) begin
                    line_end = 1'b1;
                    if (hit_h) begin
                        frame_end = 1'b1;
                        nxt       = ST_FRAME_DONE;
                    end else begin
                        nxt = ST_WAIT_LINE;
                    end
                end else begin
                    accept = 1'b1;
                    if (hit_w) begin
                        line_end = 1'b1;
                        if (hit_h) begin
                            frame_end = 1'b1;
                            nxt       = ST_FRAME_DONE;
                        end else begin
                            nxt = ST_DISCARD;
                        end
                    end
                end
            end
            ST_DISCARD: begin
                if (!frame_valid) begin
                    frame_end = 1'b1;
                    nxt       = ST_IDLE;
                end else if (!line_valid) begin
                    nxt = ST_WAIT_LINE;
                end
            end
            ST_FRAME_DONE: begin
                if (!frame_valid) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // counters and per-frame configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_cnt  <= '0;
            line_cnt <= '0;
            hsize_q  <= '0;
            vsize_q  <= '0;
            width_q  <= WM_8;
        end else if (start) begin
            pix_cnt  <= '0;
            line_cnt <= '0;
            hsize_q  <= cfg_hsize;
            vsize_q  <= cfg_vsize;
            width_q  <= wmode_e'(cfg_width);
        end else if (line_end) begin
            pix_cnt  <= '0;
            line_cnt <= line_inc;
        end else if (accept) begin
            pix_cnt  <= pix_inc;
        end
    end

endmodule

// File: rtl/cap_word_packer.sv
module cap_word_packer
    import cap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                line_end,
    input  wmode_e              width,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                push,
    output logic [WORD_W-1:0]   push_word
);

    logic [WORD_W-1:0] buf_q;
    logic [WORD_W-1:0] shifted, merged;
    logic [2:0]        slot_q, last_slot;
    logic [5:0]        shamt;
    logic [15:0]       ext;
    logic              wide;

    assign wide      = (width != WM_8);
    assign last_slot = wide ? 3'd3 : 3'd7;
    assign shamt     = wide ? {slot_q[1:0], 4'b0000} : {slot_q, 3'b000};

    always_comb begin
        unique case (width)
            WM_8:    ext = {8'b0, sample[7:0]};
            WM_9:    ext = {7'b0, sample[8:0]};
            default: ext = {6'b0, sample[9:0]};
        endcase
    end

    assign shifted   = {{(WORD_W-16){1'b0}}, ext} << shamt;
    assign merged    = accept ? (buf_q | shifted) : buf_q;
    assign push      = (accept && (slot_q == last_slot)) ||
                       (line_end && (accept || (slot_q != 3'd0)));
    assign push_word = merged;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q  <= '0;
            slot_q <= '0;
        end else if (push) begin
            buf_q  <= '0;
            slot_q <= '0;
        end else if (accept) begin
            buf_q  <= merged;
            slot_q <= slot_q + 3'd1;
        end
    end

endmodule

// File: rtl/cap_sync_fifo.sv
module cap_sync_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             rd_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             drop
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             pop, wr_ok;

    assign rd_valid = (count != '0);
    assign full     = (count == CW'(DEPTH));
    assign pop      = rd_valid && rd_ready;
    assign wr_ok    = push && (!full || pop);
    assign drop     = push && full && !pop;
    assign rd_data  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
            if (pop)   rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
            count <= count + CW'(wr_ok) - CW'(pop);
        end
    end

endmodule

// File: rtl/cap_irq_flags.sv
module cap_irq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags,
    output logic         irq
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (clr[i])    flags[i] <= 1'b0;
        end
    end

    assign irq = |(flags & mask);

endmodule

// File: rtl/cam_capture_front.sv
module cam_capture_front
    import cap_pkg::*;
#(
    parameter int  MAX_DIM    = 2048,
    parameter int  FIFO_DEPTH = 16,
    localparam int DIM_W      = $clog2(MAX_DIM + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SAMPLE_W-1:0]  pix_data,
    input  logic                 line_valid,
    input  logic                 frame_valid,
    input  logic [1:0]           cfg_width,
    input  logic [DIM_W-1:0]     cfg_hsize,
    input  logic [DIM_W-1:0]     cfg_vsize,
    input  logic                 cfg_capture_en,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 rd_valid,
    input  logic                 rd_ready,
    input  logic [NUM_FLAGS-1:0] flag_clear,
    input  logic [NUM_FLAGS-1:0] irq_mask,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);

    logic                 accept, line_end, frame_end;
    wmode_e               width_q;
    logic                 push, fifo_full, ovf_ev;
    logic [WORD_W-1:0]    push_word;
    logic [NUM_FLAGS-1:0] flag_set;

    cap_frame_fsm #(.DIM_W(DIM_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_valid    (frame_valid),
        .line_valid     (line_valid),
        .cfg_capture_en (cfg_capture_en),
        .cfg_width      (cfg_width),
        .cfg_hsize      (cfg_hsize),
        .cfg_vsize      (cfg_vsize),
        .accept         (accept),
        .line_end       (line_end),
        .frame_end      (frame_end),
        .width_q        (width_q)
    );

    cap_word_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .line_end  (line_end),
        .width     (width_q),
        .sample    (pix_data),
        .push      (push),
        .push_word (push_word)
    );

    cap_sync_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_word),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .full      (fifo_full),
        .drop      (ovf_ev)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_EOL] = line_end;
        flag_set[FLAG_EOF] = frame_end;
        flag_set[FLAG_OVF] = ovf_ev;
    end

    cap_irq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set),
        .clr    (flag_clear),
        .mask   (irq_mask),
        .flags  (flags),
        .irq    (irq)
    );

endmodule

// File: rtl/cap_capture_checker.sv
module cap_capture_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_valid,
    input logic        line_valid,
    input logic        rd_valid,
    input logic        rd_ready,
    input logic [63:0] rd_data,
    input logic [2:0]  flag_clear,
    input logic [2:0]  flags,
    input logic        irq,
    input logic        accept,
    input logic        fifo_full
);

    assert_accept_in_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (frame_valid && line_valid))
        else $error("sample accepted outside an active line");

    assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)))
        else $error("head word changed while not taken");

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags != 3'b000) |=> (((flags ^ $past(flags)) & $past(flags) & ~$past(flag_clear)) == 3'b000))
        else $error("flag dropped without a clear");

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(fifo_full))
        else $error("overflow flag set while FIFO had room");

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000))
        else $error("interrupt with no flag set");

endmodule

bind cam_capture_front cap_capture_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .line_valid  (line_valid),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_data     (rd_data),
    .flag_clear  (flag_clear),
    .flags       (flags),
    .irq         (irq),
    .accept      (accept),
    .fifo_full   (fifo_full)
);

// File: tb/cam_capture_front_test.sv
`timescale 1ns/1ps
module cam_capture_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  pix_data = '0;
    logic        line_valid = 1'b0;
    logic        frame_valid = 1'b0;
    logic [1:0]  cfg_width = '0;
    logic [11:0] cfg_hsize = 12'd4;
    logic [11:0] cfg_vsize = 12'd2;
    logic        cfg_capture_en = 1'b0;
    logic [63:0] rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [2:0]  flag_clear = '0;
    logic [2:0]  irq_mask = 3'b111;
    logic [2:0]  flags;
    logic        irq;

    int total = 0;
    int bad = 0;
    int fid = 0;
    logic [63:0] got[$];
    logic [63:0] exp_q[$];

    always #4 clk = ~clk;

    cam_capture_front uut (
        .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .line_valid(line_valid),
        .frame_valid(frame_valid), .cfg_width(cfg_width), .cfg_hsize(cfg_hsize),
        .cfg_vsize(cfg_vsize), .cfg_capture_en(cfg_capture_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .flag_clear(flag_clear),
        .irq_mask(irq_mask), .flags(flags), .irq(irq)
    );

    always @(negedge clk) begin
        #2;
        if (rd_valid && rd_ready) got.push_back(rd_data);
    end

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [9:0] pv(input int f, input int l, input int p);
        logic [9:0] r;
        r = 10'(f * 37 + l * 13 + p * 5 + 3);
        return r;
    endfunction

    task automatic build_exp(input int mode, input int hs, input int vs,
                             input int nlines, input int len, input int f);
        int per;
        int lw;
        logic [63:0] m;
        per = (mode == 0) ? 8 : 4;
        lw  = (mode == 0) ? 8 : 16;
        m   = (mode == 0) ? 64'h0FF : (mode == 1) ? 64'h1FF : 64'h3FF;
        for (int l = 0; l < nlines && l < vs; l++) begin
            int n;
            int k;
            logic [63:0] w;
            n = (len < hs) ? len : hs;
            k = 0;
            w = '0;
            for (int p = 0; p < n; p++) begin
                w = w | ((64'(pv(f, l, p)) & m) << (k * lw));
                k++;
                if (k == per) begin
                    exp_q.push_back(w);
                    w = '0;
                    k = 0;
                end
            end
            if (k > 0) exp_q.push_back(w);
        end
    endtask

    task automatic send_frame(input int nlines, input int len, input int f, input bit flip_en);
        @(negedge clk) frame_valid = 1'b1;
        @(negedge clk);
        if (flip_en) cfg_capture_en = ~cfg_capture_en;
        for (int l = 0; l < nlines; l++) begin
            for (int p = 0; p < len; p++) begin
                @(negedge clk);
                line_valid = 1'b1;
                pix_data   = pv(f, l, p);
            end
            @(negedge clk);
            line_valid = 1'b0;
            pix_data   = 10'h155;
            @(negedge clk);
        end
        @(negedge clk) frame_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic compare_words(input string req, input string what);
        chk(got.size() == exp_q.size(), req, {what, " word count"}, 64'(got.size()), 64'(exp_q.size()));
        if (got.size() == exp_q.size()) begin
            foreach (exp_q[i]) chk(got[i] == exp_q[i], req, what, got[i], exp_q[i]);
        end
        got.delete();
        exp_q.delete();
    endtask

    task automatic clear_flags();
        @(negedge clk) flag_clear = 3'b111;
        @(negedge clk) flag_clear = 3'b000;
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(flags == 3'b000, "R11", "flags after reset", 64'(flags), 64'h0);
        chk(irq == 1'b0, "R11", "irq after reset", 64'(irq), 64'h0);
        chk(rd_valid == 1'b0, "R11", "rd_valid after reset", 64'(rd_valid), 64'h0);

        // R1 R2 R3 R4 R5 sweep over formats, widths and heights
        for (int mode = 0; mode < 3; mode++) begin
            for (int vs = 2; vs <= 4; vs += 2) begin
                for (int hs = 1; hs <= 9; hs++) begin
                    for (int d = 0; d < 3; d++) begin
                        int len;
                        len = (d == 0) ? hs - 1 : (d == 1) ? hs : hs + 2;
                        if (len < 1) continue;
                        cfg_width      = 2'(mode);
                        cfg_hsize      = 12'(hs);
                        cfg_vsize      = 12'(vs);
                        cfg_capture_en = 1'b1;
                        build_exp(mode, hs, vs, 3, len, fid);
                        send_frame(3, len, fid, 1'b0);
                        repeat (3) @(negedge clk);
                        #1;
                        compare_words("R1 R2 R3 R4 R5", "swept frame data");
                        chk(flags == 3'b011, "R8", "flags after swept frame", 64'(flags), 64'h3);
                        clear_flags();
                        fid++;
                    end
                end
            end
        end

        // R1 code 3 behaves as 10-bit
        cfg_width = 2'd3; cfg_hsize = 12'd5; cfg_vsize = 12'd1; cfg_capture_en = 1'b1;
        build_exp(2, 5, 1, 1, 5, fid);
        send_frame(1, 5, fid, 1'b0);
        repeat (3) @(negedge clk);
        compare_words("R1", "format code 3");
        clear_flags();
        fid++;

        // R6 disabled at frame rise, enabled mid-frame: nothing captured
        cfg_width = 2'd0; cfg_hsize = 12'd4; cfg_vsize = 12'd4; cfg_capture_en = 1'b0;
        send_frame(2, 4, fid, 1'b1);
        repeat (3) @(negedge clk); #1;
        chk(got.size() == 0, "R6", "words from disabled frame", 64'(got.size()), 64'h0);
        chk(flags == 3'b000, "R6", "flags from disabled frame", 64'(flags), 64'h0);
        got.delete();
        fid++;

        // R6 enabled at frame rise, disabled mid-frame: frame still captured
        cfg_capture_en = 1'b1;
        build_exp(0, 4, 4, 2, 4, fid);
        send_frame(2, 4, fid, 1'b1);
        repeat (3) @(negedge clk);
        compare_words("R6", "mid-frame disable ignored");
        clear_flags();
        fid++;

        // R4 R8 collision: word fills on the line-closing sample; clear meets set
        cfg_capture_en = 1'b1; cfg_width = 2'd0; cfg_hsize = 12'd8; cfg_vsize = 12'd8;
        build_exp(0, 8, 8, 2, 8, fid);
        @(negedge clk) frame_valid = 1'b1;
        @(negedge clk);
        for (int l = 0; l < 2; l++) begin
            for (int p = 0; p < 8; p++) begin
                @(negedge clk);
                line_valid = 1'b1;
                pix_data   = pv(fid, l, p);
                if (l == 1 && p == 7) flag_clear = 3'b001;
            end
            @(negedge clk);
            line_valid = 1'b0;
            flag_clear = 3'b000;
            #1;
            if (l == 1) chk(flags[0] == 1'b1, "R8", "set wins over same-cycle clear", 64'(flags[0]), 64'h1);
        end
        @(negedge clk) flag_clear = 3'b001;
        @(negedge clk) flag_clear = 3'b000;
        #1;
        chk(flags[0] == 1'b0, "R8", "isolated clear", 64'(flags[0]), 64'h0);
        chk(flags[1] == 1'b0, "R5", "no frame end before fall", 64'(flags[1]), 64'h0);
        @(negedge clk) frame_valid = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk(flags == 3'b010, "R5", "frame end on frame fall", 64'(flags), 64'h2);
        compare_words("R4", "full word on line end, single push");
        fid++;

        // R10 mask
        irq_mask = 3'b000; #1;
        chk(irq == 1'b0, "R10", "irq with mask 000", 64'(irq), 64'h0);
        irq_mask = 3'b010; #1;
        chk(irq == 1'b1, "R10", "irq with mask 010", 64'(irq), 64'h1);
        irq_mask = 3'b101; #1;
        chk(irq == 1'b0, "R10", "irq with mask 101", 64'(irq), 64'h0);
        clear_flags();

        // R9 R7 overflow and drain order
        rd_ready = 1'b0; irq_mask = 3'b100;
        cfg_width = 2'd0; cfg_hsize = 12'd2048; cfg_vsize = 12'd1;
        build_exp(0, 2048, 1, 1, 144, fid);
        send_frame(1, 144, fid, 1'b0);
        #1;
        chk(rd_valid == 1'b1, "R7", "rd_valid while full", 64'(rd_valid), 64'h1);
        chk(flags == 3'b111, "R9", "flags after overflow", 64'(flags), 64'h7);
        chk(irq == 1'b1, "R10", "overflow irq", 64'(irq), 64'h1);
        @(negedge clk) rd_ready = 1'b1;
        repeat (24) @(negedge clk);
        #1;
        chk(rd_valid == 1'b0, "R7", "FIFO empty after drain", 64'(rd_valid), 64'h0);
        while (exp_q.size() > 16) void'(exp_q.pop_back());
        compare_words("R7 R9", "stored words after overflow");
        clear_flags();

        summary();
        $finish;
    end

endmodule